// File: doc/BRIEF.md
# Raw Delay-Line Snapshot Recorder

This block is the calibration path of a multi-line time interpolator. Sixteen tapped delay lines each present a 200-bit register image of the taps every clock. For calibration the encoders are bypassed: one line, picked by a selector, is written unencoded into an on-chip snapshot buffer each time a trigger fires. The recorded images let a host find the taps that sit out of order, and the design does not need to be rebuilt to do this.

The trigger comes from one of two sources. The first is a tick derived from the system clock through a programmable divider. With this source the delay line records the clock edge itself. The second is the rising edge of an external pulse. Capture stops when the buffer holds 256 images, and a done flag then goes high. The host drains the buffer one byte at a time through a registered read port, and a clear control rewinds the write position. When the enable input is low, the whole path is idle, so it can be left dormant once calibration is over.

Top module: `tdl_raw_capture`

## Requirements
- R1: After synchronous reset, `count` is 0, `done` is 0 and `rd_data` is 0.
- R2: While `enable` is low, no capture happens, whatever `ext_pulse`, `trig_src` and `div_n` do, and the divider is held at its start.
- R3: With `trig_src` = 1 (external source), exactly one capture happens per low-to-high transition of `ext_pulse`. It happens at the first rising clock edge where `ext_pulse` is sampled high after having been sampled low. A pulse held high does not capture again.
- R4: A capture stores bits `[k*200 +: 200]` of `snap_bus`, with k = `line_sel`, as sampled at the capturing edge. It writes them unencoded into the next free entry, so entries fill in capture order starting at entry 0, and `count` rises by one.
- R5: With `trig_src` = 0 (divided source) and `div_n` = N >= 2, the first capture is at the Nth rising edge after `enable` goes high, and later captures follow every N edges. For N of 0 or 1, a capture happens at every edge.
- R6: `clear` high at an edge sets `count` to 0, so the next capture lands in entry 0. `clear` wins over a trigger at the same edge, and no capture happens then.
- R7: `count` stops at 256. `done` is high exactly when `count` is 256. Triggers while full change neither `count` nor stored entries.
- R8: `rd_addr[12:5]` picks the entry and `rd_addr[4:0]` picks a byte b. One edge later, `rd_data` holds bits `[8b+7:8b]` of that entry for b < 25, and 0 for b from 25 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows triggering and capture when high |
| trig_src | input | 1 | Trigger source: 0 divided clock, 1 external pulse |
| div_n | input | 8 | Divider ratio N for the divided source |
| ext_pulse | input | 1 | External trigger, synchronous to clk |
| line_sel | input | 4 | Index of the delay line to record |
| snap_bus | input | 3200 | All sixteen 200-bit line images, line k at bits k*200 upward |
| clear | input | 1 | Rewinds the write position to entry 0 |
| rd_addr | input | 13 | Read address: entry in upper 8 bits, byte in lower 5 |
| rd_data | output | 8 | Registered read byte |
| count | output | 9 | Number of entries stored |
| done | output | 1 | High when the buffer is full |

## Verification
The bench holds `ext_pulse` high for several cycles. A design that detected level instead of edge would record a burst of duplicates. It counts the edges from enable to each divided-clock capture, so a divider that is off by one would store images from the wrong cycles, and `div_n` = 1 checks that a ratio of one fires every edge. It asserts `clear` in the same cycle as a trigger, where a design with the wrong priority would leave `count` at 1. It overruns the full buffer by 44 triggers, where a design without the stop would wrap and overwrite entry 0. The byte reads past byte 24 must return zeros rather than wrapped tap data.

// File: rtl/rawcap_pkg.sv
package rawcap_pkg;

    localparam int RC_LINES = 16;
    localparam int RC_TAPS  = 200;
    localparam int RC_DEPTH = 256;
    localparam int RC_DIVW  = 8;

    typedef enum logic {
        SRC_DIV = 1'b0,
        SRC_EXT = 1'b1
    } trig_src_e;

    typedef struct packed {
        logic tick;   // divider period end
        logic rise;   // external low-to-high transition
    } trig_evt_t;

    // True on the last cycle of a divider period; ratios 0 and 1 end every cycle.
    function automatic logic period_end(input int unsigned cnt, input int unsigned n);
        return (n <= 1) || (cnt == n - 1);
    endfunction

endpackage

// File: rtl/rawcap_trigger.sv
module rawcap_trigger
    import rawcap_pkg::*;
#(
    parameter int DIVW = RC_DIVW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  trig_src_e       src,
    input  logic [DIVW-1:0] div_n,
    input  logic            ext_pulse,
    output logic            fire
);
    logic [DIVW-1:0] cnt;
    logic            ext_q;
    trig_evt_t       ev;

    always_comb begin
        ev.tick = period_end(32'(cnt), 32'(div_n));
        ev.rise = ext_pulse & ~ext_q;
        fire    = enable & ((src == SRC_EXT) ? ev.rise : ev.tick);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_pulse;
            if (!enable || ev.tick) cnt <= '0;
            else                    cnt <= cnt + 1'b1;
        end
    end

    // R3: an external pulse held high never fires on two edges in a row
    assert_ext_single_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && src == SRC_EXT) |=> (!fire || src != SRC_EXT));

    // R5: a divider ratio of two or more leaves a gap after each tick
    assert_div_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        (fire && src == SRC_DIV && div_n >= 2) |=> (!fire || src != SRC_DIV || div_n <= 1));

    // R2: with enable low the divider sits at its start value
    assert_div_parked_R2: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt == '0));

endmodule

// File: rtl/rawcap_line_mux.sv
module rawcap_line_mux #(
    parameter int NLINES = 16,
    parameter int WIDTH  = 200,
    localparam int SELW  = $clog2(NLINES)
) (
    input  logic [NLINES*WIDTH-1:0] bus,
    input  logic [SELW-1:0]         sel,
    output logic [WIDTH-1:0]        line
);
    logic [WIDTH-1:0] lines [NLINES];

    for (genvar g = 0; g < NLINES; g++) begin : g_unpack
        assign lines[g] = bus[g*WIDTH +: WIDTH];
    end

    assign line = lines[sel];

endmodule

// File: rtl/rawcap_buffer.sv
module rawcap_buffer #(
    parameter int WIDTH  = 200,
    parameter int DEPTH  = 256,
    localparam int PTRW  = $clog2(DEPTH) + 1,
    localparam int ENTW  = $clog2(DEPTH),
    localparam int NBYTES = (WIDTH + 7) / 8,
    localparam int BSELW = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [ENTW-1:0]  rd_entry,
    input  logic [BSELW-1:0] rd_byte,
    output logic [7:0]       rd_data,
    output logic [PTRW-1:0]  count,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic             do_write;

    function automatic logic [7:0] byte_of(input logic [WIDTH-1:0] w, input logic [BSELW-1:0] b);
        logic [7:0] r;
        r = '0;
        for (int k = 0; k < 8; k++) begin
            if (32'(b) * 8 + k < WIDTH) r[k] = w[32'(b) * 8 + k];
        end
        return r;
    endfunction

    assign full     = (count == PTRW'(DEPTH));
    assign do_write = wr_en && !full && !clear;

    always_ff @(posedge clk) begin
        if (rst)           count <= '0;
        else if (clear)    count <= '0;
        else if (do_write) count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst && do_write) mem[count[ENTW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)                       rd_data <= '0;
        else if (32'(rd_byte) < NBYTES) rd_data <= byte_of(mem[rd_entry], rd_byte);
        else                           rd_data <= '0;
    end

    // R8: byte indices past the image read as zero
    assert_pad_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (32'(rd_byte) >= NBYTES) |=> (rd_data == 8'h00));

    // R7: the fill level never exceeds the depth
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        count <= PTRW'(DEPTH));

endmodule

// File: rtl/tdl_raw_capture.sv
module tdl_raw_capture
    import rawcap_pkg::*;
#(
    parameter int NLINES = RC_LINES,
    parameter int TAPS   = RC_TAPS,
    parameter int DEPTH  = RC_DEPTH,
    parameter int DIVW   = RC_DIVW,
    localparam int SELW  = $clog2(NLINES),
    localparam int PTRW  = $clog2(DEPTH) + 1,
    localparam int ENTW  = $clog2(DEPTH),
    localparam int BSELW = $clog2((TAPS + 7) / 8),
    localparam int ADDRW = ENTW + BSELW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic                   trig_src,
    input  logic [DIVW-1:0]        div_n,
    input  logic                   ext_pulse,
    input  logic [SELW-1:0]        line_sel,
    input  logic [NLINES*TAPS-1:0] snap_bus,
    input  logic                   clear,
    input  logic [ADDRW-1:0]       rd_addr,
    output logic [7:0]             rd_data,
    output logic [PTRW-1:0]        count,
    output logic                   done
);
    logic            fire;
    logic [TAPS-1:0] picked;
    trig_src_e       src;

    assign src = trig_src_e'(trig_src);

    rawcap_trigger #(.DIVW(DIVW)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .src       (src),
        .div_n     (div_n),
        .ext_pulse (ext_pulse),
        .fire      (fire)
    );

    rawcap_line_mux #(.NLINES(NLINES), .WIDTH(TAPS)) u_mux (
        .bus  (snap_bus),
        .sel  (line_sel),
        .line (picked)
    );

    rawcap_buffer #(.WIDTH(TAPS), .DEPTH(DEPTH)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .wr_en    (fire),
        .wr_data  (picked),
        .rd_entry (rd_addr[ADDRW-1:BSELW]),
        .rd_byte  (rd_addr[BSELW-1:0]),
        .rd_data  (rd_data),
        .count    (count),
        .full     (done)
    );

    // R2: nothing is stored while the path is switched off
    assert_gated_R2: assert property (@(posedge clk) disable iff (rst)
        (!enable && !clear) |=> $stable(count));

    // R6: clear rewinds to entry 0 even when a trigger coincides
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0));

    // R4: each accepted trigger advances the fill by one
    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (fire && !done && !clear) |=> (count == $past(count) + PTRW'(1)));

    // R7: a full buffer stays full until cleared
    assert_hold_full_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !clear) |=> (done && $stable(count)));

endmodule

// File: tb/sim_tdl_raw_capture.sv
module sim_tdl_raw_capture;
    localparam int NL = 16;
    localparam int TP = 200;

    logic          clk = 1'b0;
    logic          rst;
    logic          enable;
    logic          trig_src;
    logic [7:0]    div_n;
    logic          ext_pulse;
    logic [3:0]    line_sel;
    logic [NL*TP-1:0] snap_bus;
    logic          clear;
    logic [12:0]   rd_addr;
    logic [7:0]    rd_data;
    logic [8:0]    count;
    logic          done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [TP-1:0] exp_q [$];

    always #4 clk = ~clk;   // 125 MHz

    tdl_raw_capture u0 (
        .clk(clk), .rst(rst), .enable(enable), .trig_src(trig_src), .div_n(div_n),
        .ext_pulse(ext_pulse), .line_sel(line_sel), .snap_bus(snap_bus), .clear(clear),
        .rd_addr(rd_addr), .rd_data(rd_data), .count(count), .done(done)
    );

    function automatic logic [TP-1:0] mk_line(input int seed, input int ln);
        logic [TP-1:0] r;
        logic [31:0]   x;
        x = (32'(seed) * 32'd40503) ^ (32'(ln) * 32'd977) | 32'd1;
        for (int i = 0; i < TP; i++) begin
            x = x ^ (x << 13);
            x = x ^ (x >> 17);
            x = x ^ (x << 5);
            r[i] = x[0];
        end
        return r;
    endfunction

    task automatic set_snap(input int seed);
        for (int l = 0; l < NL; l++) snap_bus[l*TP +: TP] = mk_line(seed, l);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor side of the scoreboard: reads entries back and pops expectations
    task automatic drain(input string req, input int n);
        logic [TP-1:0] got;
        logic [TP-1:0] exp;
        for (int e = 0; e < n; e++) begin
            for (int b = 0; b < TP/8; b++) begin
                rd_addr = {8'(e), 5'(b)};
                step();
                got[b*8 +: 8] = rd_data;
            end
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL %s: entry %0d actual %h expected nothing queued", req, e, got);
            end else begin
                exp = exp_q.pop_front();
                if (got != exp) begin
                    n_fail++;
                    $display("FAIL %s: entry %0d actual %h expected %h", req, e, got, exp);
                end
            end
        end
    endtask

    task automatic do_clear();
        clear = 1'b1;
        step();
        clear = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; enable = 1'b0; trig_src = 1'b0; div_n = 8'd1; ext_pulse = 1'b0;
        line_sel = '0; clear = 1'b0; rd_addr = '0; set_snap(0);
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: reset state
        chk("R1 count", int'(count), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 rd_data", int'(rd_data), 0);

        // R2: switched off, both sources stimulated
        for (int j = 0; j < 12; j++) begin
            trig_src = j[1];
            ext_pulse = j[0];
            set_snap(50 + j);
            step();
        end
        ext_pulse = 1'b0;
        chk("R2 no capture while disabled", int'(count), 0);

        // R3 / R4: external edges, level held high, line selection
        trig_src = 1'b1; enable = 1'b1;
        step();
        set_snap(11); line_sel = 4'd5; ext_pulse = 1'b1; exp_q.push_back(mk_line(11, 5));
        step();
        set_snap(12);
        repeat (3) step();
        ext_pulse = 1'b0;
        step();
        set_snap(13); line_sel = 4'd15; ext_pulse = 1'b1; exp_q.push_back(mk_line(13, 15));
        step();
        ext_pulse = 1'b0;
        step();
        set_snap(14); line_sel = 4'd0; ext_pulse = 1'b1; exp_q.push_back(mk_line(14, 0));
        step();
        ext_pulse = 1'b0; enable = 1'b0;
        step();
        chk("R3 one capture per rising edge", int'(count), 3);
        drain("R4 external captures", 3);
        do_clear();
        chk("R6 clear rewinds count", int'(count), 0);

        // R5: divide by 4, captures on edges 4, 8, 12 after enable
        trig_src = 1'b0; div_n = 8'd4;
        for (int j = 1; j <= 12; j++) begin
            set_snap(100 + j);
            line_sel = 4'(j);
            if (j == 1) enable = 1'b1;
            if (j % 4 == 0) exp_q.push_back(mk_line(100 + j, j % 16));
            step();
        end
        enable = 1'b0;
        step();
        chk("R5 divide-by-4 count", int'(count), 3);
        drain("R5 divide-by-4 samples", 3);
        do_clear();

        // R5: ratio of one fires every edge
        div_n = 8'd1;
        for (int j = 1; j <= 5; j++) begin
            set_snap(150 + j);
            line_sel = 4'd9;
            if (j == 1) enable = 1'b1;
            exp_q.push_back(mk_line(150 + j, 9));
            step();
        end
        enable = 1'b0;
        step();
        chk("R5 ratio one count", int'(count), 5);
        drain("R5 ratio one samples", 5);
        do_clear();

        // R6: clear coinciding with a trigger wins
        trig_src = 1'b1; enable = 1'b1;
        step();
        clear = 1'b1; ext_pulse = 1'b1; set_snap(200);
        step();
        clear = 1'b0; ext_pulse = 1'b0;
        step();
        chk("R6 clear beats trigger", int'(count), 0);
        set_snap(201); line_sel = 4'd7; ext_pulse = 1'b1; exp_q.push_back(mk_line(201, 7));
        step();
        ext_pulse = 1'b0; enable = 1'b0;
        step();
        chk("R6 next capture count", int'(count), 1);
        drain("R6 capture lands in entry 0", 1);
        do_clear();

        // R7: overrun the buffer by 44 triggers
        trig_src = 1'b0; div_n = 8'd1;
        for (int j = 1; j <= 300; j++) begin
            set_snap(1000 + j);
            line_sel = 4'(j);
            if (j == 1) enable = 1'b1;
            if (j <= 256) exp_q.push_back(mk_line(1000 + j, j % 16));
            step();
        end
        enable = 1'b0;
        step();
        chk("R7 count saturates", int'(count), 256);
        chk("R7 done when full", int'(done), 1);

        // R8: bytes past the image read zero
        rd_addr = {8'd3, 5'd25};
        step();
        chk("R8 byte 25 pads zero", int'(rd_data), 0);
        rd_addr = {8'd3, 5'd31};
        step();
        chk("R8 byte 31 pads zero", int'(rd_data), 0);

        drain("R7 full buffer contents", 256);
        do_clear();
        chk("R7 done drops after clear", int'(done), 0);
        chk("R6 count after clearing full", int'(count), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule